// File: doc/BRIEF.md
# Multi-Cycle 8-bit Accumulator Processor

This block is a small control processor with an 8-bit data path and a 16-bit address space. Program, data and I/O registers all sit in one memory space, reached through a single-port memory interface. There are no separate I/O instructions. Software sees three pieces of state: an accumulator, a general register and a zero flag. Inside the block are a program counter, an address register, an instruction register, a data buffer and a byte holder that keeps the first address byte of a three-byte instruction.

A finite-state controller fetches each opcode and waits for the memory's one-cycle read latency. It then steps through the instruction, using one to seven execution steps. Sixteen operations are encoded in the low nibble of the opcode. The high nibble must be zero; any other value makes the byte a one-byte no-op. Instructions that touch memory or change control flow take two more bytes, a 16-bit direct address sent low byte first. Every other instruction is a single byte.

The memory port is a plain request port, not a stream. A read or write strobe is valid for exactly the cycle in which it is high. The memory must always accept it, so there is no back-pressure and no stall input. Read data must appear on the cycle after the read strobe.

Top module: `acc_cpu8`

## Requirements
- R1: On reset the program counter, accumulator, general register and zero flag clear. In the first cycle after reset is released the block reads address 0x0000 with mem_rd high and mem_wr low.
- R2: A one-byte instruction occupies three cycles: opcode read, instruction load, execute. The next opcode read comes three cycles after the previous one, at the following address.
- R3: Opcode 0x01 (load) reads the address low byte and then the high byte. It reads memory at that address in cycle 6, counted from the opcode read, and copies the byte into the accumulator. The next opcode read is in cycle 9, and the zero flag is left unchanged.
- R4: Opcode 0x02 (store) drives the accumulator on mem_wdata with a one-cycle mem_wr in cycle 7, addressed by the assembled address. An opcode read follows in cycle 8.
- R5: Opcode 0x03 copies the accumulator into the general register. Opcode 0x04 copies the general register into the accumulator. Neither one changes the zero flag.
- R6: Opcode 0x08 sets the accumulator to the accumulator plus the register. Opcode 0x09 sets it to the accumulator minus the register. Opcode 0x0A adds one to the accumulator. All three wrap modulo 256.
- R7: Opcode 0x0B clears the accumulator. Opcodes 0x0C, 0x0D and 0x0E apply bitwise AND, OR and XOR of the accumulator with the register. Opcode 0x0F inverts the accumulator.
- R8: The zero flag is written only by opcodes 0x08 to 0x0F. It is then set exactly when the new accumulator value is zero.
- R9: Opcode 0x05 always continues execution at its 16-bit operand.
- R10: Opcode 0x06 jumps when the zero flag is set, and opcode 0x07 jumps when it is clear. When the jump is not taken, execution continues at the byte after the three-byte instruction.
- R11: An opcode with a non-zero high nibble is a one-byte no-op. It changes no register or flag, and the next opcode read follows three cycles later.
- R12: mem_rd and mem_wr are never high together. Read data is taken on the cycle after the strobe.
- R13: Each read of an instruction-stream byte is followed one cycle later by the program counter having advanced by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address for the current access |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | 8 | Write data, valid while mem_wr is high |
| mem_rdata | input | 8 | Read data from the synchronous memory |

## Verification
Memory strobes are combinational from the controller state, so each one is due at a fixed cycle counted from its opcode read: three cycles for one-byte instructions, nine for a load and eight for a store. The write strobe of a store is due in cycle 7 and the operand read of a load in cycle 6. The bench releases reset on a falling edge and then counts falling edges, sampling each strobe and address at exactly its cycle index. Register results and flag values are never sampled mid-instruction. Each program stores them to memory and is given a generous fixed run time before the memory model is read, so only the ordering of bus events carries timing claims.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_LDAC = 4'h1, OP_STAC = 4'h2, OP_MVAC = 4'h3,
    OP_MOVR = 4'h4, OP_JUMP = 4'h5, OP_JMPZ = 4'h6, OP_JPNZ = 4'h7,
    OP_ADD  = 4'h8, OP_SUB  = 4'h9, OP_INAC = 4'hA, OP_CLAC = 4'hB,
    OP_AND  = 4'hC, OP_OR   = 4'hD, OP_XOR  = 4'hE, OP_NOT  = 4'hF
  } op_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_IRLD, ST_EXEC, ST_ALO, ST_AHI, ST_AHIW,
    ST_MRD, ST_MRDW, ST_MLD, ST_SDR, ST_SWR
  } state_e;

  typedef enum logic [1:0] {
    AC_KEEP, AC_ALU, AC_DR, AC_R
  } acsel_e;

  typedef struct packed {
    logic   addr_ar;
    logic   rd;
    logic   wr;
    logic   pc_inc;
    logic   pc_jmp;
    logic   ir_ld;
    logic   tr_ld;
    logic   ar_ld;
    logic   dr_mem;
    logic   dr_ac;
    acsel_e ac_sel;
    logic   r_ld;
    logic   z_ld;
  } ctl_t;

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rreg,
  output logic [DW-1:0] res
);

  always_comb begin
    case (op)
      OP_ADD:  res = acc + rreg;
      OP_SUB:  res = acc - rreg;
      OP_INAC: res = acc + DW'(1);
      OP_CLAC: res = '0;
      OP_AND:  res = acc & rreg;
      OP_OR:   res = acc | rreg;
      OP_XOR:  res = acc ^ rreg;
      OP_NOT:  res = ~acc;
      default: res = acc;
    endcase
  end

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ir,
  input  logic          z,
  output ctl_t          ctl,
  output logic          exec_st
);

  state_e st_q, st_d;
  op_e    op;
  logic   legal;

  assign op      = op_e'(ir[3:0]);
  assign legal   = ~|ir[DW-1:4];
  assign exec_st = (st_q == ST_EXEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FETCH;
    else        st_q <= st_d;
  end

  always_comb begin
    ctl  = '0;
    st_d = ST_FETCH;
    case (st_q)
      ST_FETCH: begin
        ctl.rd     = 1'b1;
        ctl.pc_inc = 1'b1;
        st_d       = ST_IRLD;
      end
      ST_IRLD: begin
        ctl.ir_ld = 1'b1;
        st_d      = ST_EXEC;
      end
      ST_EXEC: begin
        if (legal) begin
          case (op)
            OP_LDAC, OP_STAC, OP_JUMP, OP_JMPZ, OP_JPNZ: begin
              ctl.rd     = 1'b1;
              ctl.pc_inc = 1'b1;
              st_d       = ST_ALO;
            end
            OP_MVAC: ctl.r_ld   = 1'b1;
            OP_MOVR: ctl.ac_sel = AC_R;
            OP_ADD, OP_SUB, OP_INAC, OP_CLAC,
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
              ctl.ac_sel = AC_ALU;
              ctl.z_ld   = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_ALO: begin
        ctl.tr_ld = 1'b1;
        st_d      = ST_AHI;
      end
      ST_AHI: begin
        ctl.rd     = 1'b1;
        ctl.pc_inc = 1'b1;
        st_d       = ST_AHIW;
      end
      ST_AHIW: begin
        ctl.ar_ld = 1'b1;
        case (op)
          OP_LDAC: st_d = ST_MRD;
          OP_STAC: st_d = ST_SDR;
          OP_JUMP: ctl.pc_jmp = 1'b1;
          OP_JMPZ: ctl.pc_jmp = z;
          OP_JPNZ: ctl.pc_jmp = ~z;
          default: ;
        endcase
      end
      ST_MRD: begin
        ctl.addr_ar = 1'b1;
        ctl.rd      = 1'b1;
        st_d        = ST_MRDW;
      end
      ST_MRDW: begin
        ctl.dr_mem = 1'b1;
        st_d       = ST_MLD;
      end
      ST_MLD: ctl.ac_sel = AC_DR;
      ST_SDR: begin
        ctl.dr_ac = 1'b1;
        st_d      = ST_SWR;
      end
      ST_SWR: begin
        ctl.addr_ar = 1'b1;
        ctl.wr      = 1'b1;
      end
      default: st_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/cpu8_dpath.sv
module cpu8_dpath
  import cpu8_pkg::*;
#(
  parameter  int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] ir_q,
  output logic          z_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] ar_q,
  output logic [DW-1:0] ac_q
);

  logic [DW-1:0] dr_q, tr_q, r_q, alu_res;
  logic [AW-1:0] operand;

  assign operand   = {mem_rdata, tr_q};
  assign mem_addr  = ctl.addr_ar ? ar_q : pc_q;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign mem_wdata = dr_q;

  cpu8_alu #(.DW(DW)) u_alu (
    .op   (op_e'(ir_q[3:0])),
    .acc  (ac_q),
    .rreg (r_q),
    .res  (alu_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ar_q <= '0;
      ir_q <= '0;
      dr_q <= '0;
      tr_q <= '0;
      ac_q <= '0;
      r_q  <= '0;
      z_q  <= 1'b0;
    end else begin
      if (ctl.pc_jmp)      pc_q <= operand;
      else if (ctl.pc_inc) pc_q <= pc_q + AW'(1);
      if (ctl.ar_ld) ar_q <= operand;
      if (ctl.ir_ld) ir_q <= mem_rdata;
      if (ctl.tr_ld) tr_q <= mem_rdata;
      if (ctl.dr_mem)     dr_q <= mem_rdata;
      else if (ctl.dr_ac) dr_q <= ac_q;
      case (ctl.ac_sel)
        AC_ALU:  ac_q <= alu_res;
        AC_DR:   ac_q <= dr_q;
        AC_R:    ac_q <= r_q;
        default: ;
      endcase
      if (ctl.r_ld) r_q <= ac_q;
      if (ctl.z_ld) z_q <= (alu_res == '0);
    end
  end

endmodule

// File: rtl/acc_cpu8.sv
module acc_cpu8
  import cpu8_pkg::*;
#(
  parameter  int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  ctl_t          ctl;
  logic          exec_st;
  logic          z_q;
  logic [DW-1:0] ir_q, ac_q;
  logic [AW-1:0] pc_q, ar_q;

  cpu8_ctrl #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ir      (ir_q),
    .z       (z_q),
    .ctl     (ctl),
    .exec_st (exec_st)
  );

  cpu8_dpath #(.DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .ir_q      (ir_q),
    .z_q       (z_q),
    .pc_q      (pc_q),
    .ar_q      (ar_q),
    .ac_q      (ac_q)
  );

endmodule

// File: rtl/cpu8_chk.sv
module cpu8_chk #(
  parameter  int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] ar_q,
  input logic [DW-1:0] ac_q,
  input logic          z_q,
  input logic          z_ld,
  input logic          pc_src,
  input logic          exec_st,
  input logic [DW-5:0] ir_hi
);

  // R12
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R4
  store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == ar_q));

  // R4
  store_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (mem_rd && pc_src && !mem_wr));

  // R13
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && pc_src) |=> (pc_q == $past(pc_q) + AW'(1)));

  // R8
  z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !z_ld |=> $stable(z_q));

  // R8
  z_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z_ld |=> (z_q == (ac_q == '0)));

  // R11
  bad_op_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_st && (ir_hi != '0)) |=> (mem_rd && pc_src && $stable(ac_q) && $stable(z_q)));

endmodule

bind acc_cpu8 cpu8_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .pc_q     (pc_q),
  .ar_q     (ar_q),
  .ac_q     (ac_q),
  .z_q      (z_q),
  .z_ld     (ctl.z_ld),
  .pc_src   (!ctl.addr_ar),
  .exec_st  (exec_st),
  .ir_hi    (ir_q[DW-1:4])
);

// File: tb/acc_cpu8_test.sv
module acc_cpu8_test;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BITS   = 12;
  localparam int WDOG       = 20000;
  localparam int NVEC       = 16;

  // {opcode, R operand, AC operand, expected result, expected Z}
  localparam logic [32:0] VECS [NVEC] = '{
    {8'h08, 8'h11, 8'h22, 8'h33, 1'b0},
    {8'h08, 8'h80, 8'h80, 8'h00, 1'b1},
    {8'h09, 8'h05, 8'h05, 8'h00, 1'b1},
    {8'h09, 8'h01, 8'h00, 8'hFF, 1'b0},
    {8'h0A, 8'h00, 8'hFF, 8'h00, 1'b1},
    {8'h0A, 8'h00, 8'h41, 8'h42, 1'b0},
    {8'h0B, 8'h12, 8'h34, 8'h00, 1'b1},
    {8'h0C, 8'hF0, 8'h0F, 8'h00, 1'b1},
    {8'h0C, 8'hF3, 8'h3C, 8'h30, 1'b0},
    {8'h0D, 8'hF0, 8'h0F, 8'hFF, 1'b0},
    {8'h0E, 8'hAA, 8'hAA, 8'h00, 1'b1},
    {8'h0E, 8'h0F, 8'hFF, 8'hF0, 1'b0},
    {8'h0F, 8'h00, 8'h5A, 8'hA5, 1'b0},
    {8'h04, 8'h3C, 8'h00, 8'h3C, 1'b0},
    {8'h00, 8'h77, 8'h00, 8'h00, 1'b0},
    {8'h18, 8'h01, 8'h02, 8'h02, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem [0:(1<<MEM_BITS)-1];

  int n_tests = 0;
  int n_fail  = 0;

  acc_cpu8 uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[MEM_BITS-1:0]] = mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[MEM_BITS-1:0]];
  end

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < (1 << MEM_BITS); i++) mem[i] = 8'h00;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put3(int a, logic [7:0] op, logic [15:0] tgt);
    mem[a]   = op;
    mem[a+1] = tgt[7:0];
    mem[a+2] = tgt[15:8];
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // Vector walk: R6 R7 R8 R5 R11 R10 R9 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      hold_reset();
      put3(0, 8'h01, 16'h0800);
      mem[3] = 8'h03;
      put3(4, 8'h01, 16'h0801);
      mem[7] = VECS[v][32:25];
      put3(8, 8'h02, 16'h0810);
      put3(11, 8'h07, 16'h0014);
      put3(14, 8'h01, 16'h0803);
      put3(17, 8'h05, 16'h0017);
      put3(20, 8'h01, 16'h0802);
      put3(23, 8'h02, 16'h0811);
      put3(26, 8'h05, 16'h001A);
      mem[12'h800] = VECS[v][24:17];
      mem[12'h801] = VECS[v][16:9];
      mem[12'h802] = 8'h00;
      mem[12'h803] = 8'h01;
      mem[12'h810] = 8'hEE;
      mem[12'h811] = 8'hEE;
      release_reset();
      wait_cycles(120);
      check($sformatf("R6/R7/R5/R11 vector %0d result", v),
            int'(mem[12'h810]), int'(VECS[v][8:1]));
      check($sformatf("R8 vector %0d zero flag", v),
            int'(mem[12'h811]), int'(VECS[v][0]));
    end

    // R1 R2: reset state and one-byte instruction timing
    hold_reset();
    release_reset();
    check("R1 first read strobe", int'(mem_rd), 1);
    check("R1 first address", int'(mem_addr), 0);
    check("R1 no write after reset", int'(mem_wr), 0);
    wait_cycles(1);
    check("R2 no read in load step", int'(mem_rd), 0);
    wait_cycles(2);
    check("R2 next fetch strobe", int'(mem_rd), 1);
    check("R2 next fetch address", int'(mem_addr), 1);

    // R4: store timing, and R1 accumulator cleared by reset
    hold_reset();
    put3(0, 8'h02, 16'h0900);
    release_reset();
    wait_cycles(6);
    check("R4 no write before cycle 7", int'(mem_wr), 0);
    wait_cycles(1);
    check("R4 write strobe cycle 7", int'(mem_wr), 1);
    check("R4 write address", int'(mem_addr), 16'h0900);
    check("R1 reset accumulator stored", int'(mem_wdata), 0);
    check("R12 no read during write", int'(mem_rd), 0);
    wait_cycles(1);
    check("R4 fetch after store", int'(mem_rd), 1);
    check("R4 fetch address after store", int'(mem_addr), 3);

    // R3: load timing and data
    hold_reset();
    put3(0, 8'h01, 16'h0840);
    put3(3, 8'h02, 16'h0841);
    mem[12'h840] = 8'h9C;
    release_reset();
    wait_cycles(6);
    check("R3 operand read strobe", int'(mem_rd), 1);
    check("R3 operand read address", int'(mem_addr), 16'h0840);
    wait_cycles(3);
    check("R3 next fetch cycle 9", int'(mem_rd), 1);
    check("R3 next fetch address", int'(mem_addr), 3);
    wait_cycles(20);
    check("R3 loaded value stored", int'(mem[12'h841]), 8'h9C);

    // R9 R10: taken and not-taken jumps
    hold_reset();
    mem[0] = 8'h0B;
    put3(1, 8'h07, 16'h0040);
    mem[4] = 8'h0A;
    put3(5, 8'h06, 16'h0040);
    put3(8, 8'h07, 16'h0020);
    put3(11, 8'h02, 16'h0811);
    put3(16'h20, 8'h02, 16'h0812);
    mem[16'h23] = 8'h0B;
    put3(16'h24, 8'h06, 16'h0030);
    put3(16'h27, 8'h02, 16'h0811);
    mem[16'h30] = 8'h0A;
    put3(16'h31, 8'h02, 16'h0813);
    put3(16'h34, 8'h05, 16'h0034);
    put3(16'h40, 8'h02, 16'h0811);
    mem[12'h811] = 8'h5A;
    mem[12'h812] = 8'h00;
    mem[12'h813] = 8'h00;
    release_reset();
    wait_cycles(150);
    check("R10 skipped paths left untouched", int'(mem[12'h811]), 8'h5A);
    check("R10 taken jump on nonzero", int'(mem[12'h812]), 1);
    check("R10 R9 taken jump on zero", int'(mem[12'h813]), 1);
    check("R9 self jump keeps fetching its opcode", int'(mem_addr >= 16'h34 && mem_addr <= 16'h36), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule